// File: doc/BRIEF.md
# Dual-Loop Synthesizer Mode Controller

This block is the digital control and status logic for a frequency synthesizer with two phase-locked loops, called IF and RF. It receives bits from a control register that is already latched. It also receives four signals from each loop: a locked flag, a phase-error pulse, the reference-divider output and the programmable-divider output. From these it drives one shared status pin, whose source is chosen by a four-bit mode field. It also drives the per-loop divider enables, the counter resets and the charge-pump controls: high impedance, polarity and current scale.

Per-loop vectors use index 0 for the IF loop and index 1 for the RF loop.

The status pin can show one of the following sources:
- either loop's lock state, or the combined lock state of both loops;
- either loop's reference-divider output;
- either loop's programmable-divider output;
- a fastlock switch that pulls the pin low;
- a constant low.

One mode code holds every counter in reset. When that code is removed, the N and R counters are released on the same clock edge. Powerdown of one loop disables that loop's N counter and charge pump. The R counter and the oscillator input stay enabled until both loops are powered down.

Top module: `synth_mode_ctrl`

## Requirements
- R1: The mode field is mode_bits = {rf_lock_sel, if_lock_sel, rf_div_sel, if_div_sel}, bit 3 down to bit 0. Code 4'b0000 drives stat_pin low.
- R2: With both divider-select bits at 0, stat_pin shows lock, and a loop counts as locked when its locked flag is 1 and its phase-error pulse is 0. Code 0100 shows IF lock, code 1000 shows RF lock, and code 1100 is high only when both loops count as locked.
- R3: With if_lock_sel = 1, code x101 outputs the IF programmable divider and code x110 outputs the RF programmable divider. Bit 3 has no effect on the result.
- R4: With if_lock_sel = 0, code x001 outputs the IF reference divider and code x010 outputs the RF reference divider. Bit 3 has no effect on the result.
- R5: Code 0011 is fastlock. stat_pin is low while cp_hi[1] (the RF current bit) is 1, and high otherwise.
- R6: Code 1111 is counter reset and drives stat_pin low. From the clock edge after the code is applied, r_rst and both n_rst bits are 1. They all return to 0 on the same edge, namely the first edge after the code is removed. All three are 1 while rst_n is low.
- R7: The reserved codes 0111 and 1011 drive stat_pin low.
- R8: loop_pd[i] = 1 drives n_en[i] to 0 and cp_hiz[i] to 1. It leaves the other loop's n_en and cp_hiz unchanged.
- R9: r_en and osc_en are 1 unless both loop_pd bits are 1.
- R10: cp_tri[i] = 1 drives cp_hiz[i] to 1. The 3-bit field of cp_scale for loop i is 4 when cp_hi[i] is 1 and 1 when cp_hi[i] is 0. The IF field is bits [2:0] and the RF field is bits [5:3].
- R11: cp_pos[i] follows cp_pol[i], where 1 means positive phase-detector polarity and 0 means negative.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_bits | input | 4 | Status-pin mode field |
| loop_pd | input | 2 | Powerdown bit per loop |
| loop_locked | input | 2 | Locked flag per loop |
| phase_err | input | 2 | Phase-error pulse per loop |
| ref_div | input | 2 | Reference-divider output per loop |
| prog_div | input | 2 | Programmable-divider output per loop |
| cp_hi | input | 2 | Charge-pump high-current bit per loop |
| cp_pol | input | 2 | Phase-detector polarity bit per loop |
| cp_tri | input | 2 | Charge-pump tristate bit per loop |
| stat_pin | output | 1 | Shared multiplexed status pin |
| n_en | output | 2 | N-counter enable per loop |
| n_rst | output | 2 | N-counter reset per loop |
| r_rst | output | 1 | R-counter reset |
| r_en | output | 1 | R-counter enable |
| osc_en | output | 1 | Oscillator input enable |
| cp_hiz | output | 2 | Charge-pump high impedance per loop |
| cp_pos | output | 2 | Positive polarity per loop |
| cp_scale | output | 6 | Charge-pump current scale, 3 bits per loop |

## Verification
The bench drives every mode code, including the codes where bit 3 is a don't-care. For each code it sets the unselected sources opposite to the selected one. A decoder that read the wrong bit, or treated bit 3 as significant, would therefore show the wrong source's level on the pin. The combined-lock cases lose lock on one loop at a time, so a design that ORed the two loops instead of ANDing them fails. The counter-reset test samples both the entry edge and the release edge, so an N reset that released one cycle apart from the R reset is reported. All four powerdown combinations are applied, so an R counter that stopped when only one loop was powered down is caught.

// File: rtl/synth_mode_pkg.sv
// Shared constants for the dual-loop synthesizer mode controller.
// Assumes two loops, with index 0 for IF and index 1 for RF.
package synth_mode_pkg;
    localparam int NLOOP  = 2;
    localparam int IF_IDX = 0;
    localparam int RF_IDX = 1;

    localparam logic [3:0] MODE_OFF   = 4'b0000;
    localparam logic [3:0] MODE_FAST  = 4'b0011;
    localparam logic [3:0] MODE_CRST  = 4'b1111;
endpackage

// File: rtl/smc_pin_mux.sv
// Decodes the four-bit mode field and selects the source of the shared status pin.
// Assumes that all inputs are already synchronous to clk. The output is combinational.
module smc_pin_mux
    import synth_mode_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [3:0]       mode_bits,
    input  logic [NLOOP-1:0] loop_locked,
    input  logic [NLOOP-1:0] phase_err,
    input  logic [NLOOP-1:0] ref_div,
    input  logic [NLOOP-1:0] prog_div,
    input  logic             rf_cp_hi,
    output logic             pin
);
    logic [NLOOP-1:0] lock_ok;
    logic [1:0]       ld_sel;
    logic [1:0]       fo_sel;

    // A loop counts as locked only when it is not emitting a phase-error pulse.
    always_comb lock_ok = loop_locked & ~phase_err;

    // Split the mode field into its lock-select pair and its divider-select pair.
    always_comb begin
        ld_sel = mode_bits[3:2];
        fo_sel = mode_bits[1:0];
    end

    // Choose the pin level from the decoded mode.
    always_comb begin
        pin = 1'b0;
        unique case (fo_sel)
            2'b00: begin
                unique case (ld_sel)
                    2'b00: pin = 1'b0;
                    2'b01: pin = lock_ok[IF_IDX];
                    2'b10: pin = lock_ok[RF_IDX];
                    2'b11: pin = &lock_ok;
                endcase
            end
            2'b01: pin = mode_bits[2] ? prog_div[IF_IDX] : ref_div[IF_IDX];
            2'b10: pin = mode_bits[2] ? prog_div[RF_IDX] : ref_div[RF_IDX];
            2'b11: pin = (ld_sel == 2'b00) ? ~rf_cp_hi : 1'b0;
        endcase
    end

    p_off_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_bits == MODE_OFF) |-> !pin);
    p_fast_closed_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_bits == MODE_FAST && rf_cp_hi) |-> !pin);
    p_err_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_bits == 4'b0100 && phase_err[IF_IDX]) |-> !pin);
    p_crst_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_bits == MODE_CRST) |-> !pin);
endmodule

// File: rtl/smc_rst_seq.sv
// Counter-reset sequencer. While the counter-reset code is present it holds the R counter and
// both N counters in reset, and it releases all of them on one shared clock edge.
// Assumes that mode_bits is stable around clk edges.
module smc_rst_seq
    import synth_mode_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [3:0]       mode_bits,
    output logic             r_rst,
    output logic [NLOOP-1:0] n_rst
);
    logic hold_q;

    // Register the counter-reset request. Counters are held in reset during the block reset.
    always_ff @(posedge clk) begin
        if (!rst_n) hold_q <= 1'b1;
        else        hold_q <= (mode_bits == MODE_CRST);
    end

    // Drive the R reset and the N resets from one flop so that they release together.
    always_comb begin
        r_rst = hold_q;
        n_rst = {NLOOP{hold_q}};
    end

    p_enter_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_bits == MODE_CRST) |=> (r_rst && (&n_rst)));
    p_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_bits != MODE_CRST) |=> (!r_rst && !(|n_rst)));
endmodule

// File: rtl/smc_loop_gate.sv
// Per-loop powerdown gating and charge-pump control, plus the shared enables
// for the R counter and the oscillator input.
// Assumes that the powerdown bits come from the latched control register.
module smc_loop_gate
    import synth_mode_pkg::*;
#(
    parameter int CP_HI_SCALE = 4,
    localparam int CP_LO_SCALE = CP_HI_SCALE / 4,
    localparam int SCALE_W     = $clog2(CP_HI_SCALE + 1)
)(
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NLOOP-1:0]         loop_pd,
    input  logic [NLOOP-1:0]         cp_hi,
    input  logic [NLOOP-1:0]         cp_pol,
    input  logic [NLOOP-1:0]         cp_tri,
    output logic [NLOOP-1:0]         n_en,
    output logic [NLOOP-1:0]         cp_hiz,
    output logic [NLOOP-1:0]         cp_pos,
    output logic [NLOOP*SCALE_W-1:0] cp_scale,
    output logic                     r_en,
    output logic                     osc_en
);
    for (genvar i = 0; i < NLOOP; i++) begin : g_loop
        // Gate this loop's N counter and charge pump, and set its current scale.
        always_comb begin
            n_en[i]   = ~loop_pd[i];
            cp_hiz[i] = loop_pd[i] | cp_tri[i];
            cp_pos[i] = cp_pol[i];
            cp_scale[i*SCALE_W +: SCALE_W] = cp_hi[i] ? SCALE_W'(CP_HI_SCALE)
                                                      : SCALE_W'(CP_LO_SCALE);
        end

        p_pd_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
            loop_pd[i] |-> (!n_en[i] && cp_hiz[i]));
        p_tri_hiz_r10: assert property (@(posedge clk) disable iff (!rst_n)
            cp_tri[i] |-> cp_hiz[i]);
    end

    // Keep the shared reference path enabled while at least one loop is powered up.
    always_comb begin
        r_en   = ~&loop_pd;
        osc_en = ~&loop_pd;
    end

    p_ref_alive_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!(&loop_pd)) |-> (r_en && osc_en));
endmodule

// File: rtl/synth_mode_ctrl.sv
// Top level of the dual-loop synthesizer mode controller: status-pin mux,
// counter-reset sequencing and per-loop gating.
// Assumes synchronous inputs and the synchronous active-low reset rst_n.
module synth_mode_ctrl
    import synth_mode_pkg::*;
#(
    parameter int CP_HI_SCALE = 4,
    localparam int SCALE_W    = $clog2(CP_HI_SCALE + 1)
)(
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [3:0]               mode_bits,
    input  logic [NLOOP-1:0]         loop_pd,
    input  logic [NLOOP-1:0]         loop_locked,
    input  logic [NLOOP-1:0]         phase_err,
    input  logic [NLOOP-1:0]         ref_div,
    input  logic [NLOOP-1:0]         prog_div,
    input  logic [NLOOP-1:0]         cp_hi,
    input  logic [NLOOP-1:0]         cp_pol,
    input  logic [NLOOP-1:0]         cp_tri,
    output logic                     stat_pin,
    output logic [NLOOP-1:0]         n_en,
    output logic [NLOOP-1:0]         n_rst,
    output logic                     r_rst,
    output logic                     r_en,
    output logic                     osc_en,
    output logic [NLOOP-1:0]         cp_hiz,
    output logic [NLOOP-1:0]         cp_pos,
    output logic [NLOOP*SCALE_W-1:0] cp_scale
);
    smc_pin_mux u_mux (
        .clk         (clk),
        .rst_n       (rst_n),
        .mode_bits   (mode_bits),
        .loop_locked (loop_locked),
        .phase_err   (phase_err),
        .ref_div     (ref_div),
        .prog_div    (prog_div),
        .rf_cp_hi    (cp_hi[RF_IDX]),
        .pin         (stat_pin)
    );

    smc_rst_seq u_rst (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode_bits (mode_bits),
        .r_rst     (r_rst),
        .n_rst     (n_rst)
    );

    smc_loop_gate #(.CP_HI_SCALE(CP_HI_SCALE)) u_gate (
        .clk      (clk),
        .rst_n    (rst_n),
        .loop_pd  (loop_pd),
        .cp_hi    (cp_hi),
        .cp_pol   (cp_pol),
        .cp_tri   (cp_tri),
        .n_en     (n_en),
        .cp_hiz   (cp_hiz),
        .cp_pos   (cp_pos),
        .cp_scale (cp_scale),
        .r_en     (r_en),
        .osc_en   (osc_en)
    );
endmodule

// File: tb/tb_synth_mode_ctrl.sv
module tb_synth_mode_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] mode_bits = 4'b0000;
    logic [1:0] loop_pd = 2'b00, loop_locked = 2'b00, phase_err = 2'b00;
    logic [1:0] ref_div = 2'b00, prog_div = 2'b00;
    logic [1:0] cp_hi = 2'b00, cp_pol = 2'b00, cp_tri = 2'b00;
    logic       stat_pin, r_rst, r_en, osc_en;
    logic [1:0] n_en, n_rst, cp_hiz, cp_pos;
    logic [5:0] cp_scale;

    int errors = 0;
    int checks = 0;

    always #10 clk = ~clk;

    synth_mode_ctrl dut (
        .clk(clk), .rst_n(rst_n), .mode_bits(mode_bits), .loop_pd(loop_pd),
        .loop_locked(loop_locked), .phase_err(phase_err), .ref_div(ref_div),
        .prog_div(prog_div), .cp_hi(cp_hi), .cp_pol(cp_pol), .cp_tri(cp_tri),
        .stat_pin(stat_pin), .n_en(n_en), .n_rst(n_rst), .r_rst(r_rst),
        .r_en(r_en), .osc_en(osc_en), .cp_hiz(cp_hiz), .cp_pos(cp_pos),
        .cp_scale(cp_scale)
    );

    // Entry layout: req[17:14] mode[13:10] locked[9:8] perr[7:6] ref[5:4] prog[3:2] rf_cp_hi[1] expected_pin[0]
    localparam int NV = 30;
    localparam logic [17:0] VEC [NV] = '{
        {4'd1, 4'b0000, 2'b11, 2'b00, 2'b11, 2'b11, 1'b1, 1'b0}, // R1 off
        {4'd2, 4'b0100, 2'b01, 2'b00, 2'b00, 2'b00, 1'b0, 1'b1}, // R2 IF locked
        {4'd2, 4'b0100, 2'b01, 2'b01, 2'b00, 2'b00, 1'b0, 1'b0}, // R2 IF error pulse
        {4'd2, 4'b0100, 2'b10, 2'b00, 2'b11, 2'b11, 1'b0, 1'b0}, // R2 only RF locked
        {4'd2, 4'b1000, 2'b10, 2'b00, 2'b00, 2'b00, 1'b0, 1'b1}, // R2 RF locked
        {4'd2, 4'b1000, 2'b10, 2'b10, 2'b00, 2'b00, 1'b0, 1'b0}, // R2 RF error pulse
        {4'd2, 4'b1000, 2'b01, 2'b00, 2'b11, 2'b11, 1'b0, 1'b0}, // R2 only IF locked
        {4'd2, 4'b1100, 2'b11, 2'b00, 2'b00, 2'b00, 1'b0, 1'b1}, // R2 both locked
        {4'd2, 4'b1100, 2'b01, 2'b00, 2'b00, 2'b00, 1'b0, 1'b0}, // R2 RF unlocked
        {4'd2, 4'b1100, 2'b10, 2'b00, 2'b00, 2'b00, 1'b0, 1'b0}, // R2 IF unlocked
        {4'd2, 4'b1100, 2'b11, 2'b01, 2'b00, 2'b00, 1'b0, 1'b0}, // R2 IF pulse in combined
        {4'd3, 4'b0101, 2'b00, 2'b00, 2'b10, 2'b01, 1'b0, 1'b1}, // R3 IF prog high
        {4'd3, 4'b0101, 2'b11, 2'b00, 2'b01, 2'b10, 1'b0, 1'b0}, // R3 IF prog low
        {4'd3, 4'b1101, 2'b00, 2'b00, 2'b10, 2'b01, 1'b0, 1'b1}, // R3 bit3 ignored
        {4'd3, 4'b0110, 2'b00, 2'b00, 2'b01, 2'b10, 1'b0, 1'b1}, // R3 RF prog high
        {4'd3, 4'b0110, 2'b11, 2'b00, 2'b10, 2'b01, 1'b0, 1'b0}, // R3 RF prog low
        {4'd3, 4'b1110, 2'b00, 2'b00, 2'b10, 2'b01, 1'b0, 1'b0}, // R3 bit3 ignored, low
        {4'd4, 4'b0001, 2'b00, 2'b00, 2'b01, 2'b10, 1'b0, 1'b1}, // R4 IF ref high
        {4'd4, 4'b0001, 2'b11, 2'b00, 2'b10, 2'b01, 1'b0, 1'b0}, // R4 IF ref low
        {4'd4, 4'b1001, 2'b00, 2'b00, 2'b01, 2'b10, 1'b0, 1'b1}, // R4 bit3 ignored
        {4'd4, 4'b0010, 2'b00, 2'b00, 2'b10, 2'b01, 1'b0, 1'b1}, // R4 RF ref high
        {4'd4, 4'b0010, 2'b11, 2'b00, 2'b01, 2'b10, 1'b0, 1'b0}, // R4 RF ref low
        {4'd4, 4'b1010, 2'b00, 2'b00, 2'b10, 2'b01, 1'b0, 1'b1}, // R4 bit3 ignored
        {4'd5, 4'b0011, 2'b11, 2'b00, 2'b11, 2'b11, 1'b1, 1'b0}, // R5 switch closed
        {4'd5, 4'b0011, 2'b00, 2'b00, 2'b00, 2'b00, 1'b0, 1'b1}, // R5 switch open
        {4'd7, 4'b0111, 2'b11, 2'b00, 2'b11, 2'b11, 1'b0, 1'b0}, // R7 reserved
        {4'd7, 4'b1011, 2'b11, 2'b00, 2'b11, 2'b11, 1'b0, 1'b0}, // R7 reserved
        {4'd7, 4'b0111, 2'b11, 2'b00, 2'b11, 2'b11, 1'b1, 1'b0}, // R7 reserved, RF hi
        {4'd6, 4'b1111, 2'b11, 2'b00, 2'b11, 2'b11, 1'b0, 1'b0}, // R6 pin low
        {4'd1, 4'b0000, 2'b00, 2'b00, 2'b00, 2'b00, 1'b0, 1'b0}  // R1 off again
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    initial begin : watchdog
        #(20 * 200000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin : main
        // Reset state, R6: all counters are held in reset while rst_n is low.
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R6 reset r_rst", {7'd0, r_rst}, 8'd1);
        check("R6 reset n_rst", {6'd0, n_rst}, 8'd3);
        rst_n = 1'b1;
        @(negedge clk);
        check("R6 idle release", {5'd0, r_rst, n_rst}, 8'd0);

        // Walk the mode table.
        for (int k = 0; k < NV; k++) begin
            @(negedge clk);
            mode_bits   = VEC[k][13:10];
            loop_locked = VEC[k][9:8];
            phase_err   = VEC[k][7:6];
            ref_div     = VEC[k][5:4];
            prog_div    = VEC[k][3:2];
            cp_hi       = {VEC[k][1], 1'b0};
            #1;
            check($sformatf("R%0d vec %0d", VEC[k][17:14], k), {7'd0, stat_pin}, {7'd0, VEC[k][0]});
        end

        // R6: entry and release of counter reset on shared edges.
        @(negedge clk);
        mode_bits = 4'b1111;
        @(negedge clk);
        check("R6 enter", {5'd0, r_rst, n_rst}, 8'h07);
        @(negedge clk);
        check("R6 held", {5'd0, r_rst, n_rst}, 8'h07);
        mode_bits = 4'b0100;
        #1;
        check("R6 still held before edge", {5'd0, r_rst, n_rst}, 8'h07);
        @(negedge clk);
        check("R6 release together", {5'd0, r_rst, n_rst}, 8'h00);

        // R8 and R9: every powerdown combination.
        for (int p = 0; p < 4; p++) begin
            @(negedge clk);
            loop_pd = 2'(p);
            cp_tri  = 2'b00;
            #1;
            check($sformatf("R8 n_en pd=%0d", p), {6'd0, n_en}, {6'd0, ~2'(p)});
            check($sformatf("R8 cp_hiz pd=%0d", p), {6'd0, cp_hiz}, {6'd0, 2'(p)});
            check($sformatf("R9 r_en pd=%0d", p), {6'd0, r_en, osc_en},
                  (p == 3) ? 8'd0 : 8'd3);
        end

        // R10: tristate and current scale.
        @(negedge clk);
        loop_pd = 2'b00;
        cp_tri  = 2'b10;
        cp_hi   = 2'b01;
        #1;
        check("R10 tristate RF", {6'd0, cp_hiz}, 8'h02);
        check("R10 scale IF hi RF lo", {2'd0, cp_scale}, {2'd0, 3'd1, 3'd4});
        @(negedge clk);
        cp_tri = 2'b01;
        cp_hi  = 2'b10;
        #1;
        check("R10 tristate IF", {6'd0, cp_hiz}, 8'h01);
        check("R10 scale IF lo RF hi", {2'd0, cp_scale}, {2'd0, 3'd4, 3'd1});

        // R11: polarity follows its bit in each loop independently.
        @(negedge clk);
        cp_pol = 2'b01;
        #1;
        check("R11 polarity 01", {6'd0, cp_pos}, 8'h01);
        @(negedge clk);
        cp_pol = 2'b10;
        #1;
        check("R11 polarity 10", {6'd0, cp_pos}, 8'h02);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule